// File: doc/BRIEF.md
# Scaled Min-Sum Check Node Unit

This unit computes the check-to-variable messages of one parity check in a log-domain LDPC decoder that uses the corrected min-sum rule. It serves one base-matrix row of a semi-parallel array, so an array holds one unit per row. The unit takes the variable-to-check messages of its row serially, one per cycle. It keeps a compressed summary of them: the smallest magnitude, the second-smallest magnitude, the position of the smallest, the parity of all signs and one sign bit per edge. It then plays back one reply per edge, in arrival order. Each reply carries the extrinsic sign and the smallest magnitude among the other edges, scaled by three quarters to offset the optimism of the minimum approximation.

A row can fall asleep. After a burst that is processed normally, the row sleeps if the parity of its signs is even and its smallest magnitude is strictly above a programmable threshold. While it sleeps, each later burst is counted but its values are discarded, and the replies of the last processed burst are played back again. A frame-start pulse wakes the row.

The controller has three states. `S_IDLE` waits for the first message of a burst. `S_GATHER` takes the remaining messages. `S_EMIT` plays back the replies. The transitions are: IDLE to GATHER on the first accepted message; GATHER to EMIT on the message whose index equals the latched degree minus one; EMIT to IDLE on the reply flagged last.

Top module: `cnu_minsum_row`

## Requirements
- R1: After reset, out_valid and asleep are 0 and in_ready is 1.
- R2: Messages are Q-bit two's complement (bit Q-1 is the sign). A message's magnitude is its absolute value, except that the most negative code counts as magnitude 2^(Q-1)-1.
- R3: The reply for edge i has magnitude m - (m >> 2), where m is the smallest magnitude among all edges other than i.
- R4: The reply for edge i is negative exactly when an odd number of the other edges are negative (bit Q-1 set). A negative reply is the two's complement negation of the scaled magnitude.
- R5: When two edges share the smallest magnitude, the reply of each of them uses that same magnitude.
- R6: Replies start in the cycle after the last message is taken. There is one reply per cycle, in arrival order, and out_last marks the final one. in_ready is 0 while replies are played, and in_valid is ignored during that time.
- R7: The degree is sampled on the first message of a burst and clamped to the range 2 to MAX_DEG. Values 0 and 1 give 2, and values above MAX_DEG give MAX_DEG.
- R8: After a burst processed normally, asleep rises in the cycle after its last reply if the sign parity is even and the smallest magnitude is greater than cfg_thresh. A magnitude equal to cfg_thresh leaves asleep at 0.
- R9: While asleep, the values of a burst's messages are ignored and its replies repeat those of the last processed burst.
- R10: A new_frame pulse in S_IDLE clears asleep. If it coincides with a first message, that burst is processed normally. A pulse outside S_IDLE is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_degree | input | $clog2(MAX_DEG+1) | Row degree, sampled on the first message |
| cfg_thresh | input | Q-1 | Sleep threshold on the smallest magnitude |
| new_frame | input | 1 | Frame start, wakes the row |
| in_valid | input | 1 | Message present |
| in_msg | input | Q | Variable-to-check message |
| in_ready | output | 1 | Unit can take a message |
| out_valid | output | 1 | Reply present |
| out_msg | output | Q | Check-to-variable reply |
| out_last | output | 1 | Final reply of the burst |
| asleep | output | 1 | Row converged, updates skipped |

## Verification
The hardest situation to reach is an asleep row that receives a burst whose values differ from the stored one. The bench gets there in three steps. First it drives a burst whose minimum equals the threshold and confirms that the row stays awake. Next it raises that minimum by one, so the row falls asleep. Then it sends unrelated values and expects the earlier replies to repeat. Further steps cover a new_frame pulse held during playback, which must not wake the row, and a pulse coinciding with a first message, which must process that burst normally.

// File: rtl/cnu_pkg.sv
package cnu_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_GATHER = 2'd1,
        S_EMIT   = 2'd2
    } cnu_state_e;
endpackage

// File: rtl/cnu_mag_split.sv
// Splits a two's-complement message into sign and saturated magnitude.
module cnu_mag_split #(
    parameter int Q = 4
) (
    input  logic [Q-1:0] msg,
    output logic         neg,
    output logic [Q-2:0] mag
);
    localparam int MW = Q - 1;

    always_comb begin
        neg = msg[Q-1];
        if (msg == {1'b1, {MW{1'b0}}}) begin
            mag = '1;
        end else if (neg) begin
            mag = ~msg[Q-2:0] + MW'(1);
        end else begin
            mag = msg[Q-2:0];
        end
    end
endmodule

// File: rtl/cnu_min_track.sv
// Keeps the compressed row summary: two minima, index, parity, edge signs.
module cnu_min_track #(
    parameter int MW      = 3,
    parameter int MAX_DEG = 24,
    parameter int IW      = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               first,
    input  logic [IW-1:0]      idx,
    input  logic [MW-1:0]      mag,
    input  logic               neg,
    output logic [MW-1:0]      min1,
    output logic [MW-1:0]      min2,
    output logic [IW-1:0]      min_idx,
    output logic               par,
    output logic [MAX_DEG-1:0] signs
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min1    <= '0;
            min2    <= '0;
            min_idx <= '0;
            par     <= 1'b0;
        end else if (en) begin
            if (first) begin
                min1    <= mag;
                min2    <= '1;
                min_idx <= idx;
                par     <= neg;
            end else begin
                par <= par ^ neg;
                if (mag < min1) begin
                    min2    <= min1;
                    min1    <= mag;
                    min_idx <= idx;
                end else if (mag < min2) begin
                    min2 <= mag;
                end
            end
        end
    end

    for (genvar g = 0; g < MAX_DEG; g++) begin : g_sign
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                signs[g] <= 1'b0;
            end else if (en && (idx == IW'(g))) begin
                signs[g] <= neg;
            end
        end
    end
endmodule

// File: rtl/cnu_scale.sv
// Applies the 3/4 correction and restores the sign.
module cnu_scale #(
    parameter int MW = 3
) (
    input  logic [MW-1:0] mag,
    input  logic          neg,
    output logic [MW:0]   msg
);
    logic [MW-1:0] scaled;

    always_comb begin
        scaled = mag - (mag >> 2);
        msg    = neg ? -{1'b0, scaled} : {1'b0, scaled};
    end
endmodule

// File: rtl/cnu_minsum_row.sv
module cnu_minsum_row #(
    parameter int Q       = 4,
    parameter int MAX_DEG = 24
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(MAX_DEG+1)-1:0] cfg_degree,
    input  logic [Q-2:0]                 cfg_thresh,
    input  logic                         new_frame,
    input  logic                         in_valid,
    input  logic [Q-1:0]                 in_msg,
    output logic                         in_ready,
    output logic                         out_valid,
    output logic [Q-1:0]                 out_msg,
    output logic                         out_last,
    output logic                         asleep
);
    import cnu_pkg::*;

    localparam int MW = Q - 1;
    localparam int IW = $clog2(MAX_DEG);
    localparam int DW = $clog2(MAX_DEG + 1);

    cnu_state_e state_q, state_d;

    logic [DW-1:0] cnt_q;
    logic [DW-1:0] deg_q;
    logic [DW-1:0] deg_clamped;
    logic          burst_skip_q;
    logic          sleep_q;

    logic          accept;
    logic          first_in;
    logic          last_in;
    logic          skip_now;
    logic          upd_en;
    logic          emit_done;
    logic [IW-1:0] cur_idx;
    logic [IW-1:0] emit_idx;

    logic          in_neg;
    logic [MW-1:0] in_mag;

    logic [MW-1:0]      min1, min2;
    logic [IW-1:0]      min_idx;
    logic               par;
    logic [MAX_DEG-1:0] signs;

    logic [MW-1:0] sel_mag;
    logic          sel_neg;
    logic [MW:0]   scaled_msg;

    // ---------------- control decode ----------------
    always_comb begin
        if (cfg_degree < DW'(2)) begin
            deg_clamped = DW'(2);
        end else if (cfg_degree > DW'(MAX_DEG)) begin
            deg_clamped = DW'(MAX_DEG);
        end else begin
            deg_clamped = cfg_degree;
        end
    end

    assign in_ready  = (state_q != S_EMIT);
    assign accept    = in_valid && in_ready;
    assign first_in  = (state_q == S_IDLE);
    assign last_in   = accept && (state_q == S_GATHER) && (cnt_q == deg_q - DW'(1));
    assign skip_now  = first_in ? (sleep_q && !new_frame) : burst_skip_q;
    assign upd_en    = accept && !skip_now;
    assign cur_idx   = first_in ? '0 : cnt_q[IW-1:0];
    assign emit_idx  = cnt_q[IW-1:0];
    assign emit_done = (state_q == S_EMIT) && (cnt_q == deg_q - DW'(1));

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (accept)    state_d = S_GATHER;
            S_GATHER: if (last_in)   state_d = S_EMIT;
            S_EMIT:   if (emit_done) state_d = S_IDLE;
            default:                 state_d = S_IDLE;
        endcase
    end

    // ---------------- burst bookkeeping ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q        <= '0;
            deg_q        <= DW'(2);
            burst_skip_q <= 1'b0;
            sleep_q      <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (new_frame) begin
                        sleep_q <= 1'b0;
                    end
                    if (accept) begin
                        cnt_q        <= DW'(1);
                        deg_q        <= deg_clamped;
                        burst_skip_q <= skip_now;
                    end
                end
                S_GATHER: begin
                    if (accept) begin
                        cnt_q <= last_in ? '0 : cnt_q + DW'(1);
                    end
                end
                S_EMIT: begin
                    cnt_q <= emit_done ? '0 : cnt_q + DW'(1);
                    if (emit_done && !burst_skip_q && !par && (min1 > cfg_thresh)) begin
                        sleep_q <= 1'b1;
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // ---------------- datapath ----------------
    cnu_mag_split #(.Q(Q)) u_split (
        .msg (in_msg),
        .neg (in_neg),
        .mag (in_mag)
    );

    cnu_min_track #(.MW(MW), .MAX_DEG(MAX_DEG), .IW(IW)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (upd_en),
        .first   (first_in),
        .idx     (cur_idx),
        .mag     (in_mag),
        .neg     (in_neg),
        .min1    (min1),
        .min2    (min2),
        .min_idx (min_idx),
        .par     (par),
        .signs   (signs)
    );

    always_comb begin
        sel_mag = (emit_idx == min_idx) ? min2 : min1;
        sel_neg = par ^ signs[emit_idx];
    end

    cnu_scale #(.MW(MW)) u_scale (
        .mag (sel_mag),
        .neg (sel_neg),
        .msg (scaled_msg)
    );

    // ---------------- outputs ----------------
    always_comb begin
        out_valid = (state_q == S_EMIT);
        out_last  = emit_done;
        out_msg   = out_valid ? scaled_msg : '0;
        asleep    = sleep_q;
    end
endmodule

// File: rtl/cnu_minsum_row_sva.sv
module cnu_minsum_row_sva #(
    parameter int Q = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         new_frame,
    input logic         in_valid,
    input logic         in_ready,
    input logic         out_valid,
    input logic [Q-1:0] out_msg,
    input logic         out_last,
    input logic         asleep
);
    localparam int MAXM = (2 ** (Q - 1)) - 1;
    localparam int MAXS = MAXM - (MAXM >> 2);

    logic [7:0] icnt, ocnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            icnt <= '0;
            ocnt <= '0;
        end else if (out_valid && out_last) begin
            icnt <= '0;
            ocnt <= '0;
        end else begin
            if (in_valid && in_ready) icnt <= icnt + 8'd1;
            if (out_valid)            ocnt <= ocnt + 8'd1;
        end
    end

    // R3: reply magnitude never exceeds the scaled ceiling
    assert_reply_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (($signed(out_msg) <= MAXS) && ($signed(out_msg) >= -MAXS)));

    // R6: replies are contiguous until the last one
    assert_replies_contiguous_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> out_valid);

    // R6: one reply per message taken
    assert_reply_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> (ocnt + 8'd1 == icnt));

    // R6: playback stops after the last reply
    assert_stop_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |=> !out_valid);

    // R8: sleep only begins right after a final reply
    assert_sleep_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> $past(out_last));

    // R10: wake only follows a frame-start pulse
    assert_wake_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asleep) |-> $past(new_frame));
endmodule

bind cnu_minsum_row cnu_minsum_row_sva #(.Q(Q)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .new_frame (new_frame),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_msg   (out_msg),
    .out_last  (out_last),
    .asleep    (asleep)
);

// File: tb/cnu_minsum_row_tb.sv
`timescale 1ns/1ps
module cnu_minsum_row_tb;
    localparam int Q    = 4;
    localparam int MAXD = 24;

    typedef struct {
        int    val;
        bit    last;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] cfg_degree = 5'd4;
    logic [2:0] cfg_thresh = 3'd7;
    logic       new_frame = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] in_msg = '0;
    logic       in_ready, out_valid, out_last, asleep;
    logic [3:0] out_msg;

    int   checks = 0;
    int   fails  = 0;
    exp_t sb[$];
    int   stim[MAXD];
    int   prev_exp[MAXD];
    bit   model_sleep = 0;

    always #4 clk = ~clk;

    cnu_minsum_row #(.Q(Q), .MAX_DEG(MAXD)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_degree (cfg_degree),
        .cfg_thresh (cfg_thresh),
        .new_frame  (new_frame),
        .in_valid   (in_valid),
        .in_msg     (in_msg),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .out_msg    (out_msg),
        .out_last   (out_last),
        .asleep     (asleep)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard as replies appear
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R6 unexpected reply act=%0d exp=none", $signed(out_msg));
            end else begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (int'($signed(out_msg)) != e.val || out_last != e.last || in_ready != 1'b0) begin
                    fails++;
                    $display("FAIL %s act=%0d/last%0d/rdy%0d exp=%0d/last%0d/rdy0",
                             e.tag, $signed(out_msg), out_last, in_ready, e.val, e.last);
                end
            end
        end
    end

    // driver: computes expected replies, then drives one burst
    task automatic send(input int dcfg, input bit nf, input bit junk,
                        input bit nf_emit, input string tag);
        int  d, minall, negs;
        bit  skip;
        d = (dcfg < 2) ? 2 : ((dcfg > MAXD) ? MAXD : dcfg);
        skip = model_sleep && !nf;
        if (nf) model_sleep = 0;
        minall = 99;
        negs = 0;
        if (!skip) begin
            for (int i = 0; i < d; i++) begin
                int mn, ng, s;
                mn = 99;
                ng = 0;
                for (int j = 0; j < d; j++) begin
                    if (j != i) begin
                        int m;
                        m = (stim[j] < 0) ? -stim[j] : stim[j];
                        if (m > 7) m = 7;
                        if (m < mn) mn = m;
                        if (stim[j] < 0) ng++;
                    end
                end
                s = mn - mn / 4;
                prev_exp[i] = (ng % 2 == 1) ? -s : s;
                if (stim[i] < 0) negs++;
                begin
                    int mi;
                    mi = (stim[i] < 0) ? -stim[i] : stim[i];
                    if (mi > 7) mi = 7;
                    if (mi < minall) minall = mi;
                end
            end
        end
        for (int i = 0; i < d; i++) begin
            exp_t e;
            e.val  = prev_exp[i];
            e.last = (i == d - 1);
            e.tag  = tag;
            sb.push_back(e);
        end
        for (int i = 0; i < d; i++) begin
            @(negedge clk);
            cfg_degree = 5'(dcfg);
            in_valid   = 1'b1;
            in_msg     = 4'(stim[i]);
            new_frame  = (i == 0) && nf;
        end
        @(negedge clk);
        new_frame = nf_emit;
        if (junk) begin
            in_msg = 4'b1001;
        end else begin
            in_valid = 1'b0;
        end
        while (sb.size() != 0) @(negedge clk);
        in_valid  = 1'b0;
        new_frame = 1'b0;
        @(negedge clk);
        @(negedge clk);
        if (!skip && (negs % 2 == 0) && (minall > int'(cfg_thresh))) model_sleep = 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R6 watchdog act=hung exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 asleep", int'(asleep), 0);
        chk("R1 in_ready", int'(in_ready), 1);

        // R3 R4 basic mixed burst
        stim[0] = 3; stim[1] = -2; stim[2] = 5; stim[3] = 1;
        send(4, 0, 0, 0, "R3_R4 basic");
        // R2 saturation of most negative code
        stim[0] = -8; stim[1] = 7; stim[2] = -3; stim[3] = 4; stim[4] = -6; stim[5] = 2;
        send(6, 0, 0, 0, "R2 saturate");
        stim[0] = -8; stim[1] = -8; stim[2] = 7;
        send(3, 0, 0, 0, "R2_R4 saturate pair");
        // R5 tie on the minimum
        stim[0] = 2; stim[1] = -2; stim[2] = 5; stim[3] = 6;
        send(4, 0, 0, 0, "R5 tie");
        stim[0] = 0; stim[1] = 4; stim[2] = 0;
        send(3, 0, 0, 0, "R5 zero tie");
        // R7 degree clamp low
        stim[0] = 4; stim[1] = -7;
        send(0, 0, 0, 0, "R7 clamp low");
        stim[0] = -1; stim[1] = -5;
        send(1, 0, 0, 0, "R7 clamp one");
        // R7 clamp high, R6 junk on in_valid during playback
        for (int i = 0; i < MAXD; i++) stim[i] = ((i * 5) % 15) - 7;
        send(31, 0, 1, 0, "R7_R6 clamp high junk");
        for (int i = 0; i < MAXD; i++) stim[i] = (i == MAXD - 1) ? 1 : 6 - (i % 3);
        send(24, 0, 0, 0, "R6 max degree order");

        // R8 boundary: minimum equal to threshold keeps row awake
        cfg_thresh = 3'd4;
        stim[0] = 6; stim[1] = 7; stim[2] = -5; stim[3] = -4; stim[4] = 5;
        send(5, 0, 0, 0, "R8 boundary");
        chk("R8 equal threshold stays awake", int'(asleep), 0);
        stim[3] = -6;
        send(5, 0, 0, 0, "R8 converge");
        chk("R8 asleep after converge", int'(asleep), 1);
        // R9 asleep burst repeats previous replies
        stim[0] = 1; stim[1] = -1; stim[2] = 0; stim[3] = 2; stim[4] = -3;
        send(5, 0, 1, 1, "R9 asleep replay");
        chk("R10 pulse during playback ignored", int'(asleep), 1);
        // R10 new_frame with first message processes fresh
        stim[0] = 1; stim[1] = -2; stim[2] = 3; stim[3] = 3; stim[4] = -1;
        send(5, 1, 0, 0, "R10 fresh burst");
        chk("R10 woken by frame start", int'(asleep), 0);
        // R10 lone pulse in idle wakes the row
        stim[0] = 7; stim[1] = 7; stim[2] = 7; stim[3] = 7; stim[4] = 7;
        send(5, 0, 0, 0, "R8 converge again");
        chk("R8 asleep again", int'(asleep), 1);
        @(negedge clk); new_frame = 1'b1;
        @(negedge clk); new_frame = 1'b0;
        @(negedge clk);
        chk("R10 idle pulse wakes", int'(asleep), 0);

        chk("R6 scoreboard drained", sb.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule